// File: doc/BRIEF.md
# Sub-Word Store Merge Bridge

This bridge lets a requester store either single bytes or whole 16-bit words into a memory that only ever writes complete words. A word store is forwarded to the memory in the same cycle it is accepted. A byte store cannot be forwarded, because the memory has no lane strobes. The bridge therefore fetches the word that holds the byte and clears the lane being replaced. It then moves the new byte into that lane, ORs the two together and writes the whole word back to the same location.

The requester presents a byte address, write data, a size flag and a valid signal. A request is taken in any cycle where valid and ready are both high. The memory port is a plain synchronous word port. Its read data appears one cycle after the read is issued. The controller has three states. `ST_IDLE` accepts requests and forwards word stores. `ST_MERGE` captures the fetched word and builds the merged word. `ST_WRITE` writes the merged word back. The named transitions are T_TAKE_BYTE (`ST_IDLE` to `ST_MERGE`, when a byte store is accepted), T_MERGE_DONE (`ST_MERGE` to `ST_WRITE`, always) and T_WB_DONE (`ST_WRITE` to `ST_IDLE`, always). Every other case keeps `ST_IDLE` where it is.

Top module: `rmw_bridge`

## Requirements
- R1: While reset is asserted and directly after it, `req_ready` is 1 and both `mem_en` and `req_err` are 0.
- R2: An accepted word store (`req_byte`=0) whose address bit 0 is 0 drives `mem_en`=1 and `mem_we`=1 in its acceptance cycle. In that cycle `mem_addr` equals the byte address shifted right by one and `mem_wdata` equals `req_wdata`. `req_ready` stays 1 in the following cycle.
- R3: An accepted word store whose address bit 0 is 1 raises `req_err` in its acceptance cycle and makes no memory access. The store is dropped, so memory contents do not change, and `req_ready` stays 1.
- R4: An accepted byte store (`req_byte`=1) issues a read (`mem_en`=1, `mem_we`=0) in its acceptance cycle, with `mem_addr` equal to the byte address shifted right by one.
- R5: In the cycle after a byte store is accepted, the bridge makes no memory access and holds `req_ready` at 0.
- R6: Two cycles after a byte store is accepted, the bridge writes (`mem_en`=1, `mem_we`=1) to the same word address it read, and `req_ready` is still 0.
- R7: The written-back word replaces only the selected lane with `req_wdata[7:0]`. Address bit 0 = 0 selects bits 7:0 and address bit 0 = 1 selects bits 15:8. The other lane keeps the value that was read.
- R8: Requests presented while `req_ready` is 0 are ignored. `req_ready` returns to 1 in the cycle after the write-back, so a byte store occupies exactly three cycles and a new request can be accepted in the fourth.
- R9: After any mix of back-to-back word stores, byte stores and dropped stores, the memory holds the same words as a reference model that applies the stores in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data; for byte stores only bits 7:0 are used |
| req_byte | input | 1 | 1 = byte store, 0 = word store |
| req_err | output | 1 | Misaligned word store dropped (acceptance cycle) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W-1 | Word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after a read |

## Verification
Word stores and error flags are due in the acceptance cycle itself. For a byte store, the read is due in the acceptance cycle, the idle memory cycle one cycle later, and the write-back with the merged word two cycles later. `req_ready` is due to rise three cycles after acceptance. The bench drives inputs on the falling edge and samples 1 ns later. Each sample therefore sees the combinational response of the current state, and each check is tied to the exact cycle of the sequence in which its result is due. Requests are issued back to back. During the busy cycles the bench sometimes keeps valid asserted with a different address and data. A final comparison of every memory word against the bench's own shadow image then catches any store that was lost, duplicated or accepted when it should not have been.

// File: rtl/rmw_bridge_pkg.sv
package rmw_bridge_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MERGE = 2'd1,
        ST_WRITE = 2'd2
    } rmw_state_t;
endpackage

// File: rtl/rmw_lane_merge.sv
module rmw_lane_merge #(
    parameter int DATA_W    = 16,
    parameter int LANE_BITS = 1
) (
    input  logic [DATA_W-1:0]    old_word,
    input  logic [7:0]           new_byte,
    input  logic [LANE_BITS-1:0] lane,
    output logic [DATA_W-1:0]    merged
);
    localparam int SHIFT_W = LANE_BITS + 3;

    logic [SHIFT_W-1:0] shamt;
    logic [DATA_W-1:0]  keep_mask;
    logic [DATA_W-1:0]  placed;

    always_comb begin
        shamt     = {lane, 3'b000};
        keep_mask = ~(DATA_W'(8'hFF) << shamt);
        placed    = DATA_W'(new_byte) << shamt;
        merged    = (old_word & keep_mask) | placed;
    end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import rmw_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_byte,
    input  logic misalign,
    output logic req_ready,
    output logic issue_rd,
    output logic pass_wr,
    output logic load_merge,
    output logic wr_back,
    output logic err
);
    rmw_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid && req_byte) state_nx = ST_MERGE; // T_TAKE_BYTE
            ST_MERGE: state_nx = ST_WRITE;                            // T_MERGE_DONE
            ST_WRITE: state_nx = ST_IDLE;                             // T_WB_DONE
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        req_ready  = 1'b0;
        issue_rd   = 1'b0;
        pass_wr    = 1'b0;
        load_merge = 1'b0;
        wr_back    = 1'b0;
        err        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (req_byte)      issue_rd = 1'b1;
                    else if (misalign) err      = 1'b1;
                    else               pass_wr  = 1'b1;
                end
            end
            ST_MERGE: load_merge = 1'b1;
            ST_WRITE: wr_back    = 1'b1;
            default: ;
        endcase
    end

    assert_ready_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |=> req_ready);

    assert_merge_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_rd |=> (state == ST_MERGE));
endmodule

// File: rtl/rmw_bridge.sv
module rmw_bridge #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                req_byte,
    output logic                req_err,
    output logic                mem_en,
    output logic                mem_we,
    output logic [ADDR_W-2:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int LANE_BITS = $clog2(DATA_W / 8);
    localparam int WORD_AW   = ADDR_W - LANE_BITS;

    logic                 issue_rd, pass_wr, load_merge, wr_back;
    logic [LANE_BITS-1:0] req_lane;
    logic [WORD_AW-1:0]   req_waddr;
    logic                 misalign;

    logic [WORD_AW-1:0]   addr_q;
    logic [LANE_BITS-1:0] lane_q;
    logic [7:0]           byte_q;
    logic [DATA_W-1:0]    merged, merged_q;

    assign req_lane  = req_addr[LANE_BITS-1:0];
    assign req_waddr = req_addr[ADDR_W-1:LANE_BITS];
    assign misalign  = |req_lane;

    rmw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_byte   (req_byte),
        .misalign   (misalign),
        .req_ready  (req_ready),
        .issue_rd   (issue_rd),
        .pass_wr    (pass_wr),
        .load_merge (load_merge),
        .wr_back    (wr_back),
        .err        (req_err)
    );

    rmw_lane_merge #(.DATA_W(DATA_W), .LANE_BITS(LANE_BITS)) u_merge (
        .old_word (mem_rdata),
        .new_byte (byte_q),
        .lane     (lane_q),
        .merged   (merged)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            lane_q   <= '0;
            byte_q   <= '0;
            merged_q <= '0;
        end else begin
            if (issue_rd) begin
                addr_q <= req_waddr;
                lane_q <= req_lane;
                byte_q <= req_wdata[7:0];
            end
            if (load_merge) merged_q <= merged;
        end
    end

    always_comb begin
        mem_en    = issue_rd | pass_wr | wr_back;
        mem_we    = pass_wr | wr_back;
        mem_addr  = wr_back ? addr_q : req_waddr;
        mem_wdata = wr_back ? merged_q : req_wdata;
    end

    assert_pass_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pass_wr |-> (mem_en && mem_we && mem_wdata == req_wdata && mem_addr == req_waddr));

    assert_drop_misaligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (!mem_en && req_ready));

    assert_quiet_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_byte) |=> (!req_ready && !mem_en));

    assert_wb_same_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_back |-> (mem_we && !req_ready && mem_addr == $past(mem_addr, 2)));
endmodule

// File: tb/rmw_bridge_tb.sv
`timescale 1ns/1ps
module rmw_bridge_tb;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << (AW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_byte = 1'b0;
    logic          req_err;
    logic          mem_en, mem_we;
    logic [AW-2:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    logic [DW-1:0] mem_model [DEPTH];
    logic [DW-1:0] shadow    [DEPTH];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rmw_bridge #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_byte(req_byte),
        .req_err(req_err), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_model[i] <= '0;
            mem_rdata <= '0;
        end else if (mem_en) begin
            if (mem_we) mem_model[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem_model[mem_addr];
        end
    end

    function automatic logic [DW-1:0] f_merge(logic [DW-1:0] old, logic hi, logic [7:0] b);
        return hi ? {b, old[7:0]} : {old[15:8], b};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // caller is at a falling edge; returns at the falling edge after acceptance
    task automatic do_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_addr = a; req_wdata = d; req_byte = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R8 ready in idle", req_ready, 1);
        if (a[0]) begin
            chk(req_err == 1'b1, "R3 err flag", req_err, 1);
            chk(mem_en == 1'b0, "R3 no access", mem_en, 0);
        end else begin
            chk(req_err == 1'b0, "R2 no err", req_err, 0);
            chk(mem_en && mem_we, "R2 write issued", {mem_en, mem_we}, 2'b11);
            chk(mem_addr == a[AW-1:1], "R2 word address", mem_addr, a[AW-1:1]);
            chk(mem_wdata == d, "R2 write data", mem_wdata, d);
            shadow[a[AW-1:1]] = d;
        end
        @(negedge clk);
    endtask

    // returns at the falling edge after the write-back cycle
    task automatic do_byte(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit hold);
        logic [DW-1:0] expw;
        req_valid = 1'b1; req_addr = a; req_wdata = d; req_byte = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R8 ready in idle", req_ready, 1);
        chk(mem_en && !mem_we, "R4 read issued", {mem_en, mem_we}, 2'b10);
        chk(mem_addr == a[AW-1:1], "R4 read address", mem_addr, a[AW-1:1]);
        expw = f_merge(shadow[a[AW-1:1]], a[0], d[7:0]);
        shadow[a[AW-1:1]] = expw;
        @(negedge clk);
        if (hold) begin
            req_addr = a ^ AW'(8'h5A); req_wdata = ~d; req_byte = $urandom % 2 == 0;
        end else req_valid = 1'b0;
        #1;
        chk(req_ready == 1'b0, "R5 busy", req_ready, 0);
        chk(mem_en == 1'b0, "R5 no access", mem_en, 0);
        @(negedge clk);
        #1;
        chk(req_ready == 1'b0, "R6 busy", req_ready, 0);
        chk(mem_en && mem_we, "R6 write-back", {mem_en, mem_we}, 2'b11);
        chk(mem_addr == a[AW-1:1], "R6 same word", mem_addr, a[AW-1:1]);
        chk(mem_wdata == expw, "R7 merged word", mem_wdata, expw);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        chk(mem_en == 1'b0, "R1 no access in reset", mem_en, 0);
        chk(req_err == 1'b0, "R1 no err in reset", req_err, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(mem_en == 1'b0, "R1 idle after reset", mem_en, 0);
        @(negedge clk);

        // directed corner cases
        do_word(8'h20, 16'hA5C3);
        do_byte(8'h20, 16'hFF7E, 1'b0);   // R7 low lane -> A57E
        do_byte(8'h21, 16'h0012, 1'b1);   // R7 high lane -> 127E, R8 ignore
        do_byte(8'h21, 16'h0034, 1'b0);   // R9 back to back same word
        do_word(8'h23, 16'hDEAD);         // R3 dropped
        do_word(8'h22, 16'h0001);
        do_byte(8'h23, 16'hBE99, 1'b1);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            int kind;
            kind = int'($urandom % 4);
            a = AW'($urandom);
            d = DW'($urandom);
            case (kind)
                0, 1: do_byte(a, d, ($urandom % 2) == 0);
                2:    do_word({a[AW-1:1], 1'b0}, d);
                default: do_word({a[AW-1:1], 1'b1}, d);
            endcase
        end
        req_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R8 ready after traffic", req_ready, 1);
        for (int i = 0; i < DEPTH; i++)
            chk(mem_model[i] == shadow[i], "R9 memory image", mem_model[i], shadow[i]);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule